// File: doc/BRIEF.md
# Trigger and End-of-Conversion Sequencer

This block sets the timing of each conversion around a sample-and-hold front end. An asynchronous trigger line enters through a flop chain. The sequencer accepts the trigger only when its level stays high for a minimum width. It then raises an end-of-conversion flag (`eoc`). That flag is the hold command for the front end: hold while high, sample while low. The flag stays high for a fixed number of clock cycles. During that time the external conversion core is started with a one-cycle pulse and returns its result with a done strobe.

A fixed number of cycles before `eoc` falls, the sequencer copies the captured result to its data output. The previous result stays on the output until that point. After `eoc` falls, an acquisition window follows in which the front end settles. A trigger qualified while `eoc` is high or inside that window is ignored and sets a sticky error flag, which only reset clears.

Every interval is given in nanoseconds and turned into clock counts from the clock frequency parameter. At the default 200 MHz this gives:

| Interval | Time | Cycles |
|---|---|---|
| Minimum trigger width | 50 ns | 10 |
| Conversion (`eoc` high) | 5000 ns | 1000 |
| Data lead before `eoc` falls | 20 ns | 4 |
| Acquisition window | 1900 ns | 380 |

Top module: `eoc_sequencer`

## Requirements
- R1: After reset, `eoc`, `core_start`, `trig_err` and all bits of `dout` are 0.
- R2: A trigger is accepted only if `trig_in` is sampled high on at least PW consecutive rising clock edges (PW = minimum width in cycles). Counting the first edge that samples it high as edge 1, `eoc` is high after edge PW+2. A pulse sampled high on PW-1 edges starts nothing.
- R3: Once raised, `eoc` stays high for exactly CONV cycles (the conversion interval in cycles).
- R4: `core_start` is high for exactly one cycle, and that cycle is the first cycle in which `eoc` is high.
- R5: `dout` takes the last `core_data` value captured with `core_done` during the current `eoc`-high interval. If there was no such capture, it takes the last value captured in an earlier interval. The new value appears LEAD cycles before `eoc` falls, and `dout` holds its value in every other cycle.
- R6: After `eoc` falls, triggers are refused for ACQ cycles. A trigger whose qualifying cycle falls while `eoc` is high or inside that window starts no conversion and sets `trig_err`, which stays 1 until reset. One cycle later than that, the trigger is accepted.
- R7: A trigger held high for a long time starts only one conversion, and its still-high level does not set `trig_err`.
- R8: A `core_done` strobe while `eoc` is low does not change the value loaded at the next data point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger level |
| eoc | output | 1 | End-of-conversion flag; 1 commands hold, 0 commands sample |
| core_start | output | 1 | One-cycle start pulse to the conversion core |
| core_done | input | 1 | Conversion core result strobe |
| core_data | input | DATA_W | Conversion core result, read when `core_done` is 1 |
| dout | output | DATA_W | Presented conversion result |
| trig_err | output | 1 | Sticky flag for a refused trigger |

## Verification
The assertions assume the parameter relations checked at elaboration: LEAD is below CONV, and every interval is at least one cycle. They also assume that reset is held long enough to flush the synchronizer. The data-hold property further assumes that the core strobes `core_done` no later than the cycle before the data point.

The stimulus meets these assumptions. It drives `trig_in` and the core inputs only on falling clock edges. It places core strobes no later than that point. It holds reset for several cycles each time it is applied. Random conversions pick trigger widths, core latencies and results. Directed cases sit on both sides of the minimum-width and acquisition boundaries.

// File: rtl/eoc_pkg.sv
package eoc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CONV = 2'd1,
      PH_ACQ  = 2'd2
   } phase_e;

   // Round a time interval up to whole clock cycles, never below one.
   function automatic int ns_to_cycles(input longint clk_hz, input longint ns);
      longint c;
      c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      if (c < 1) c = 1;
      return int'(c);
   endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("trig_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= g_stage[g-1].q;
         end
      end
   end

   assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/pulse_qual.sv
module pulse_qual #(
   parameter int PW_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic accept
);

   if (PW_CYC < 1) begin : g_bad_pw
      $error("pulse_qual: PW_CYC must be at least 1");
   end

   if (PW_CYC == 1) begin : g_edge
      // One cycle is enough: plain rising-edge detect.
      logic lvl_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_d <= 1'b0;
         else        lvl_d <= lvl;
      end
      assign accept = lvl & ~lvl_d;
   end else begin : g_count
      localparam int CW = $clog2(PW_CYC + 1);
      localparam logic [CW-1:0] RUN_TOP  = CW'(PW_CYC);
      localparam logic [CW-1:0] RUN_FIRE = CW'(PW_CYC - 1);
      logic [CW-1:0] run;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              run <= '0;
         else if (!lvl)           run <= '0;
         else if (run != RUN_TOP) run <= run + 1'b1;
      end
      assign accept = lvl && (run == RUN_FIRE);
   end

   // One acceptance per high level, never two cycles in a row.
   assert_one_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !accept)
      else $error("accept asserted in two consecutive cycles");

endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
   import eoc_pkg::*;
#(
   parameter int CONV_CYC = 1000,
   parameter int ACQ_CYC  = 380,
   parameter int LEAD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   output logic eoc,
   output logic core_start,
   output logic load,
   output logic trig_err
);

   localparam int SPAN  = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC;
   localparam int CNT_W = $clog2(SPAN + 1);
   localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
   localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYC - 1);
   localparam logic [CNT_W-1:0] LOAD_AT   = CNT_W'(CONV_CYC - 1 - LEAD_CYC);

   if (CONV_CYC < 2) begin : g_bad_conv
      $error("conv_fsm: CONV_CYC must be at least 2");
   end
   if (ACQ_CYC < 1) begin : g_bad_acq
      $error("conv_fsm: ACQ_CYC must be at least 1");
   end
   if (LEAD_CYC >= CONV_CYC) begin : g_bad_lead
      $error("conv_fsm: LEAD_CYC must be below CONV_CYC");
   end

   phase_e           phase;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cnt        <= '0;
         eoc        <= 1'b0;
         core_start <= 1'b0;
         trig_err   <= 1'b0;
      end else begin
         core_start <= 1'b0;
         if (accept && (phase != PH_IDLE)) trig_err <= 1'b1;
         unique case (phase)
            PH_IDLE: begin
               if (accept) begin
                  phase      <= PH_CONV;
                  cnt        <= '0;
                  eoc        <= 1'b1;
                  core_start <= 1'b1;
               end
            end
            PH_CONV: begin
               if (cnt == CONV_LAST) begin
                  phase <= PH_ACQ;
                  cnt   <= '0;
                  eoc   <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_ACQ: begin
               if (cnt == ACQ_LAST) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
               eoc   <= 1'b0;
            end
         endcase
      end
   end

   assign load = (phase == PH_CONV) && (cnt == LOAD_AT);

   // Checker state: length of the current high interval, length of the gap.
   localparam int HI_W  = $clog2(CONV_CYC + 2);
   localparam int GAP_W = $clog2(ACQ_CYC + 2);
   localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(ACQ_CYC + 1);
   logic [HI_W-1:0]  hi_run;
   logic [GAP_W-1:0] gap_run;
   logic             had_conv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run   <= '0;
         gap_run  <= '0;
         had_conv <= 1'b0;
      end else begin
         hi_run  <= eoc ? hi_run + 1'b1 : '0;
         if (eoc)                   gap_run <= '0;
         else if (gap_run != GAP_MAX) gap_run <= gap_run + 1'b1;
         if (eoc) had_conv <= 1'b1;
      end
   end

   assert_conv_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eoc) |-> (hi_run == HI_W'(CONV_CYC)))
      else $error("eoc high interval has the wrong length");

   assert_start_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc) |-> core_start)
      else $error("eoc rose without a start pulse");

   assert_acq_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eoc) && had_conv) |-> (gap_run >= GAP_W'(ACQ_CYC)))
      else $error("conversion started inside the acquisition window");

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_err |=> trig_err)
      else $error("trig_err cleared without reset");

endmodule

// File: rtl/result_reg.sv
module result_reg #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_data,
   input  logic              load,
   output logic [DATA_W-1:0] dout
);

   if (DATA_W < 1) begin : g_bad_w
      $error("result_reg: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] staged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged <= '0;
         dout   <= '0;
      end else begin
         if (cap_en) staged <= cap_data;
         if (load)   dout   <= staged;
      end
   end

   assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(dout))
      else $error("dout changed outside the data point");

endmodule

// File: rtl/eoc_sequencer.sv
module eoc_sequencer
   import eoc_pkg::*;
#(
   parameter longint CLK_HZ       = 200_000_000,
   parameter int     CONV_NS      = 5000,
   parameter int     MIN_PULSE_NS = 50,
   parameter int     LEAD_NS      = 20,
   parameter int     ACQ_NS       = 1900,
   parameter int     DATA_W       = 18,
   parameter int     SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_in,
   output logic              eoc,
   output logic              core_start,
   input  logic              core_done,
   input  logic [DATA_W-1:0] core_data,
   output logic [DATA_W-1:0] dout,
   output logic              trig_err
);

   localparam int CONV_CYC = ns_to_cycles(CLK_HZ, longint'(CONV_NS));
   localparam int PW_CYC   = ns_to_cycles(CLK_HZ, longint'(MIN_PULSE_NS));
   localparam int LEAD_CYC = ns_to_cycles(CLK_HZ, longint'(LEAD_NS));
   localparam int ACQ_CYC  = ns_to_cycles(CLK_HZ, longint'(ACQ_NS));

   logic trig_lvl;
   logic accept;
   logic load;

   trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (trig_in),
      .dout  (trig_lvl)
   );

   pulse_qual #(.PW_CYC(PW_CYC)) i_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (trig_lvl),
      .accept (accept)
   );

   conv_fsm #(
      .CONV_CYC (CONV_CYC),
      .ACQ_CYC  (ACQ_CYC),
      .LEAD_CYC (LEAD_CYC)
   ) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .eoc        (eoc),
      .core_start (core_start),
      .load       (load),
      .trig_err   (trig_err)
   );

   result_reg #(.DATA_W(DATA_W)) i_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (core_done & eoc),
      .cap_data (core_data),
      .load     (load),
      .dout     (dout)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!core_start && !trig_err))
      else $error("outputs active during reset");

endmodule

// File: tb/test_eoc_sequencer.sv
module test_eoc_sequencer;

   localparam int W       = 18;
   localparam int CLK_MHZ = 200;
   function automatic int cyc(input int ns);
      return (ns * CLK_MHZ + 999) / 1000;
   endfunction
   localparam int PW = cyc(50);
   localparam int C  = cyc(5000);
   localparam int L  = cyc(20);
   localparam int A  = cyc(1900);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         trig_in = 1'b0;
   logic         core_done = 1'b0;
   logic [W-1:0] core_data = '0;
   logic         eoc, core_start, trig_err;
   logic [W-1:0] dout;

   int n_chk = 0;
   int n_fail = 0;
   int trig_left = 0;
   bit done_flag = 0;
   logic [W-1:0] staged = '0;
   logic [W-1:0] shown = '0;

   always #2.5 clk = ~clk;

   eoc_sequencer i_eoc_sequencer (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .eoc(eoc),
      .core_start(core_start), .core_done(core_done), .core_data(core_data),
      .dout(dout), .trig_err(trig_err)
   );

   function automatic logic [W-1:0] exp_dout(input bit respond, input logic [W-1:0] v,
                                             input logic [W-1:0] prev);
      return respond ? v : prev;
   endfunction

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (trig_left > 0) begin
         trig_left--;
         if (trig_left == 0) trig_in = 1'b0;
      end
   endtask

   task automatic raise(input int len);
      trig_in   = 1'b1;
      trig_left = len;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; trig_in = 1'b0; trig_left = 0; core_done = 1'b0;
      repeat (4) tick();
      rst_n = 1'b1;
      tick();
      staged = '0; shown = '0;
   endtask

   task automatic quiet(input int k, input string what);
      int seen = 0;
      for (int j = 0; j < k; j++) begin
         tick();
         if (eoc) seen++;
      end
      chk(seen == 0, what, seen, 0);
   endtask

   // Starts at the current falling edge, returns at the first edge with eoc low.
   task automatic run_conv(input int tlen, input int dly, input bit respond,
                           input logic [W-1:0] val, input int rt_at, input int rt_len,
                           input bit exp_err, input string tag);
      int i = 0;
      int n;
      logic [W-1:0] want;
      want = exp_dout(respond, val, staged);
      raise(tlen);
      while (!eoc && i < PW + 20) begin
         tick();
         i++;
      end
      chk(i == PW + 2, {"R2 eoc rise latency ", tag}, i, PW + 2);
      n = 1;
      while (eoc && n < C + 20) begin
         if (n == 1) chk(core_start == 1'b1, {"R4 start in first cycle ", tag}, core_start, 1);
         if (n == 2) chk(core_start == 1'b0, {"R4 start one cycle ", tag}, core_start, 0);
         if (n == C - L) chk(dout == shown, {"R5 old data held ", tag}, dout, shown);
         if (n == C - L + 1) chk(dout == want, {"R5 data at lead point ", tag}, dout, want);
         if (respond && n == dly) begin core_done = 1'b1; core_data = val; end
         if (respond && n == dly + 1) core_done = 1'b0;
         if (rt_at > 0 && n == rt_at) raise(rt_len);
         tick();
         n++;
      end
      core_done = 1'b0;
      chk(n == C + 1, {"R3 eoc length ", tag}, n - 1, C);
      chk(dout == want, {"R5 data after fall ", tag}, dout, want);
      chk(trig_err == exp_err, {"R6 error flag ", tag}, trig_err, exp_err);
      staged = want;
      shown  = want;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      do_reset();
      // R1 reset state
      chk(eoc == 1'b0, "R1 eoc after reset", eoc, 0);
      chk(core_start == 1'b0, "R1 core_start after reset", core_start, 0);
      chk(dout == '0, "R1 dout after reset", dout, 0);
      chk(trig_err == 1'b0, "R1 trig_err after reset", trig_err, 0);

      // R2 pulse one cycle too short
      raise(PW - 1);
      quiet(PW + 20, "R2 short pulse ignored");
      chk(trig_err == 1'b0, "R2 short pulse no error", trig_err, 0);

      run_conv(PW, 100, 1, 18'h2A5A5, 0, 0, 0, "min width");
      repeat (A + 5) tick();
      run_conv(PW + 40, C - L - 1, 1, 18'h3FFFF, 0, 0, 0, "late core strobe");

      // R6 earliest accepted trigger after the window
      repeat (A - PW - 1) tick();
      run_conv(PW, 7, 1, 18'h00001, 0, 0, 0, "R6 first accepted slot");

      // R7 long trigger: one conversion, no error
      repeat (A + 5) tick();
      run_conv(C + A + 200, 50, 1, 18'h1C3C3, 0, 0, 0, "R7 long trigger");
      quiet(A + 300, "R7 single conversion");
      chk(trig_err == 1'b0, "R7 no error from held level", trig_err, 0);

      // R8 strobe while idle is ignored
      core_done = 1'b1; core_data = 18'h15555;
      tick();
      core_done = 1'b0;
      repeat (5) tick();
      run_conv(PW + 3, 0, 0, 18'h0, 0, 0, 0, "R8 idle strobe ignored");

      // R6 retrigger while eoc is high
      repeat (A + 5) tick();
      run_conv(PW, 300, 1, 18'h0BEEF, 500, PW + 3, 1, "R6 retrigger in conversion");

      // R1 reset clears the sticky flag
      do_reset();
      chk(trig_err == 1'b0, "R1 reset clears trig_err", trig_err, 0);
      chk(dout == '0, "R1 reset clears dout", dout, 0);
      run_conv(PW, 20, 1, 18'h12345, 0, 0, 0, "after reset");

      // R6 last refused slot in the acquisition window
      repeat (A - PW - 2) tick();
      raise(PW);
      quiet(PW + 20, "R6 trigger in window refused");
      chk(trig_err == 1'b1, "R6 window trigger sets error", trig_err, 1);

      // Random conversions
      for (int k = 0; k < 15; k++) begin
         int tl = PW + int'($urandom % 30);
         int dl = 1 + int'($urandom % (C - L - 1));
         bit rs = ($urandom % 4) != 0;
         logic [W-1:0] v = W'($urandom);
         repeat (A + int'($urandom % 60)) tick();
         run_conv(tl, dl, rs, v, 0, 0, 1, "R5 random");
      end

      repeat (10) tick();
      finish_run();
   end

endmodule